// File: doc/BRIEF.md
# Interval Slowdown Estimator

This block keeps a bank of counters for one requester of a shared cache and memory system. At the end of each interval it estimates how much the requester is slowed down by sharing. It tracks two access rates. The shared rate is the requester's cache accesses over every cycle of the interval. The alone rate is its accesses during high-priority cycles over those cycles, after cycles lost to cache contention and to queueing behind other requesters have been removed. The slowdown is the alone rate divided by the shared rate. It is reported as an unsigned fixed-point number with 8 fractional bits.

The inputs are:
- an access strobe,
- a high-priority flag,
- tagged miss issue and miss return events,
- a contention-miss count from an auxiliary tag store,
- the ID of the requester the memory scheduler served last.

The block timestamps each outstanding miss from a free-running cycle counter. This gives the average high-priority miss service time, which is then multiplied by the contention-miss count. When an interval ends, the counters are copied and cleared. A sequential divider is then run twice: first for the average miss latency, then for the slowdown ratio.

The controller has six states:
- `ST_IDLE` waits for an interval end.
- `ST_AVG_GO` starts the latency division, or skips it when no miss completed.
- `ST_AVG_WAIT` waits for that quotient.
- `ST_SD_GO` starts the ratio division, or takes the no-access shortcut.
- `ST_SD_WAIT` waits for the ratio.
- `ST_EMIT` publishes the result and returns to `ST_IDLE`.

Top module: `slowdown_est`

## Requirements
- R1: While reset is held and in the first cycle after it, `sd_out` is 0 and `sd_done` is 0.
- R2: The shared-rate counters count every access and every cycle of the interval, including the cycle in which `interval_end` is high. All counters restart from zero after that cycle.
- R3: The alone-rate counters count the accesses and cycles in which `hi_pri` is 1.
- R4: A cycle is a queueing cycle when all three of these hold: `hi_pri` is 1, at least one miss is outstanding, and `last_sched_id` differs from the parameter `MY_ID`. A miss is outstanding from the cycle after its issue through its return cycle.
- R5: A miss returning while `hi_pri` is 1 adds (return cycle − issue cycle) to the latency sum and 1 to the completed count. The average is the floor of their quotient, or 0 when no miss completed.
- R6: Contention cycles are `cont_miss_cnt` (sampled in the `interval_end` cycle) times the average latency. The alone denominator is high-priority cycles − contention cycles − queueing cycles. It is clamped to 1 when it is zero or negative.
- R7: `sd_out` = floor(hp_accesses × all_cycles × 256 / (denominator × all_accesses)).
- R8: When the interval had no accesses, the result is 256 (1.0).
- R9: A quotient above 65535 saturates to 65535.
- R10: `sd_done` is high for exactly one cycle per estimate. `sd_out` changes only in that cycle and holds otherwise.
- R11: An `interval_end` that arrives while an estimate is still being computed produces no extra estimate and does not disturb the pending one. The counters still restart after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval_end | input | 1 | Last cycle of the current interval |
| acc_v | input | 1 | Cache access made this cycle |
| hi_pri | input | 1 | Requester holds highest memory priority |
| miss_iss_v | input | 1 | Miss issued this cycle |
| miss_iss_tag | input | TAG_W | Tag of the issued miss |
| miss_ret_v | input | 1 | Miss returned this cycle |
| miss_ret_tag | input | TAG_W | Tag of the returned miss |
| cont_miss_cnt | input | CNT_W | Contention misses in this interval |
| last_sched_id | input | RID_W | Requester served last by the scheduler |
| sd_out | output | OUT_W | Slowdown estimate, 8 fractional bits |
| sd_done | output | 1 | New estimate valid |

## Verification
An estimate is not due in a fixed cycle. The controller takes one cycle per control state, and each of the two divisions takes 2·CNT_W+8 cycles; a division is skipped when no miss completed or when there were no accesses. So the bench does not wait a fixed number of cycles. It samples outputs at falling edges and waits for the `sd_done` pulse, allowing up to 300 cycles. It then compares `sd_out` against a value it computes from its own per-cycle record of the stimulus. That record closes on the very cycle `interval_end` is driven. After each pulse, the bench keeps stepping to confirm that no second pulse appears and that the output holds.

// File: rtl/sd_pkg.sv
package sd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AVG_GO,
        ST_AVG_WAIT,
        ST_SD_GO,
        ST_SD_WAIT,
        ST_EMIT
    } sd_state_e;

    localparam int C_ACC   = 0;
    localparam int C_CYC   = 1;
    localparam int C_ACCHP = 2;
    localparam int C_CYCHP = 3;
    localparam int C_Q     = 4;
    localparam int C_LAT   = 5;
    localparam int C_ND    = 6;
    localparam int NCTR    = 7;
endpackage

// File: rtl/sd_div.sv
module sd_div #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    rem;
    logic [W-1:0]  dv;
    logic [CW-1:0] cnt;
    logic [W:0]    sh;

    assign sh = {rem[W-1:0], quo[W-1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            quo  <= '0;
            dv   <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                rem  <= '0;
                quo  <= num;
                dv   <= den;
                cnt  <= CW'(W);
                busy <= 1'b1;
            end else if (busy) begin
                if (sh >= {1'b0, dv}) begin
                    rem <= sh - {1'b0, dv};
                    quo <= {quo[W-2:0], 1'b1};
                end else begin
                    rem <= sh;
                    quo <= {quo[W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sd_miss_track.sv
module sd_miss_track #(
    parameter int TAG_W = 2,
    parameter int TS_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_v,
    input  logic [TAG_W-1:0] iss_tag,
    input  logic             ret_v,
    input  logic [TAG_W-1:0] ret_tag,
    output logic             outstanding,
    output logic [TS_W-1:0]  ret_lat
);
    localparam int NSLOT = 1 << TAG_W;

    logic [TS_W-1:0] now;
    logic [TS_W-1:0] ts  [NSLOT];
    logic            vld [NSLOT];

    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1'b1;
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[g] <= 1'b0;
                ts[g]  <= '0;
            end else if (iss_v && iss_tag == TAG_W'(g)) begin
                vld[g] <= 1'b1;
                ts[g]  <= now;
            end else if (ret_v && ret_tag == TAG_W'(g)) begin
                vld[g] <= 1'b0;
            end
        end
    end

    always_comb begin
        outstanding = 1'b0;
        for (int i = 0; i < NSLOT; i++) outstanding = outstanding | vld[i];
    end

    assign ret_lat = now - ts[ret_tag];
endmodule

// File: rtl/sd_ctr_bank.sv
module sd_ctr_bank #(
    parameter int CNT_W = 16,
    parameter int LAT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             acc_v,
    input  logic             hi_pri,
    input  logic             q_cond,
    input  logic             lat_v,
    input  logic [LAT_W-1:0] lat,
    output logic [CNT_W-1:0] nxt [sd_pkg::NCTR]
);
    import sd_pkg::*;

    logic [CNT_W-1:0] inc [NCTR];

    always_comb begin
        inc[C_ACC]   = CNT_W'(acc_v);
        inc[C_CYC]   = CNT_W'(1);
        inc[C_ACCHP] = CNT_W'(acc_v & hi_pri);
        inc[C_CYCHP] = CNT_W'(hi_pri);
        inc[C_Q]     = CNT_W'(q_cond);
        inc[C_LAT]   = lat_v ? CNT_W'(lat) : '0;
        inc[C_ND]    = CNT_W'(lat_v);
    end

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        logic [CNT_W-1:0] cur;
        assign nxt[g] = cur + inc[g];
        always_ff @(posedge clk) begin
            if (!rst_n || clear) cur <= '0;
            else                 cur <= nxt[g];
        end
    end
endmodule

// File: rtl/slowdown_est.sv
module slowdown_est #(
    parameter int CNT_W = 16,
    parameter int TS_W  = 12,
    parameter int TAG_W = 2,
    parameter int RID_W = 2,
    parameter int MY_ID = 0,
    parameter int FRAC  = 8,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             interval_end,
    input  logic             acc_v,
    input  logic             hi_pri,
    input  logic             miss_iss_v,
    input  logic [TAG_W-1:0] miss_iss_tag,
    input  logic             miss_ret_v,
    input  logic [TAG_W-1:0] miss_ret_tag,
    input  logic [CNT_W-1:0] cont_miss_cnt,
    input  logic [RID_W-1:0] last_sched_id,
    output logic [OUT_W-1:0] sd_out,
    output logic             sd_done
);
    import sd_pkg::*;

    localparam int DW = 2 * CNT_W + FRAC;
    localparam int SW = 2 * CNT_W + 2;
    localparam logic [RID_W-1:0] MY_TAG = RID_W'(MY_ID);
    localparam logic [OUT_W-1:0] ONE    = OUT_W'(1 << FRAC);

    sd_state_e state, state_n;

    logic             outstanding, q_cond, lat_v, accept;
    logic [TS_W-1:0]  ret_lat;
    logic [CNT_W-1:0] nxt  [NCTR];
    logic [CNT_W-1:0] snap [NCTR];
    logic [CNT_W-1:0] s_cont, avg, den_eff;
    logic [CNT_W-1:0] s_acc, s_nd;
    logic [2*CNT_W-1:0] cont_c, p_num, p_den;
    logic signed [SW-1:0] diff;
    logic             div_go, div_busy, div_done;
    logic [DW-1:0]    div_num, div_den, div_quo;
    logic [OUT_W-1:0] res, sat_q;

    sd_miss_track #(.TAG_W(TAG_W), .TS_W(TS_W)) u_track (
        .clk(clk), .rst_n(rst_n),
        .iss_v(miss_iss_v), .iss_tag(miss_iss_tag),
        .ret_v(miss_ret_v), .ret_tag(miss_ret_tag),
        .outstanding(outstanding), .ret_lat(ret_lat)
    );

    assign q_cond = hi_pri & outstanding & (last_sched_id != MY_TAG);
    assign lat_v  = miss_ret_v & hi_pri;
    assign accept = interval_end && (state == ST_IDLE);

    sd_ctr_bank #(.CNT_W(CNT_W), .LAT_W(TS_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clear(interval_end),
        .acc_v(acc_v), .hi_pri(hi_pri), .q_cond(q_cond),
        .lat_v(lat_v), .lat(ret_lat), .nxt(nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCTR; i++) snap[i] <= '0;
            s_cont <= '0;
        end else if (accept) begin
            for (int i = 0; i < NCTR; i++) snap[i] <= nxt[i];
            s_cont <= cont_miss_cnt;
        end
    end

    assign s_acc = snap[C_ACC];
    assign s_nd  = snap[C_ND];

    // alone denominator: high-priority cycles less contention and queueing
    assign cont_c  = (2*CNT_W)'(s_cont) * (2*CNT_W)'(avg);
    assign diff    = $signed(SW'(snap[C_CYCHP])) - $signed(SW'(cont_c))
                   - $signed(SW'(snap[C_Q]));
    assign den_eff = (diff <= 0) ? CNT_W'(1) : diff[CNT_W-1:0];
    assign p_num   = (2*CNT_W)'(snap[C_ACCHP]) * (2*CNT_W)'(snap[C_CYC]);
    assign p_den   = (2*CNT_W)'(den_eff) * (2*CNT_W)'(s_acc);

    always_comb begin
        div_go  = 1'b0;
        div_num = DW'(snap[C_LAT]);
        div_den = DW'(s_nd);
        if (state == ST_AVG_GO) begin
            div_go = (s_nd != '0);
        end else if (state == ST_SD_GO) begin
            div_go  = (s_acc != '0);
            div_num = {p_num, FRAC'(0)};
            div_den = DW'(p_den);
        end
    end

    sd_div #(.W(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go),
        .num(div_num), .den(div_den),
        .busy(div_busy), .done(div_done), .quo(div_quo)
    );

    assign sat_q = (|div_quo[DW-1:OUT_W]) ? '1 : div_quo[OUT_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:     if (interval_end) state_n = ST_AVG_GO;
            ST_AVG_GO:   state_n = (s_nd != '0) ? ST_AVG_WAIT : ST_SD_GO;
            ST_AVG_WAIT: if (div_done) state_n = ST_SD_GO;
            ST_SD_GO:    state_n = (s_acc != '0) ? ST_SD_WAIT : ST_EMIT;
            ST_SD_WAIT:  if (div_done) state_n = ST_EMIT;
            ST_EMIT:     state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avg     <= '0;
            res     <= '0;
            sd_out  <= '0;
            sd_done <= 1'b0;
        end else begin
            sd_done <= (state == ST_EMIT);
            if (accept)                               avg <= '0;
            if (state == ST_AVG_WAIT && div_done)     avg <= div_quo[CNT_W-1:0];
            if (state == ST_SD_GO && s_acc == '0)     res <= ONE;
            if (state == ST_SD_WAIT && div_done)      res <= sat_q;
            if (state == ST_EMIT)                     sd_out <= res;
        end
    end
endmodule

// File: rtl/sd_chk.sv
module sd_chk #(
    parameter int CNT_W = 16,
    parameter int OUT_W = 16,
    parameter int FRAC  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              interval_end,
    input logic              sd_done,
    input logic [OUT_W-1:0]  sd_out,
    input sd_pkg::sd_state_e state,
    input logic              div_go,
    input logic              div_busy,
    input logic [CNT_W-1:0]  s_acc
);
    import sd_pkg::*;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sd_done |=> !sd_done); // R10
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_done |-> $stable(sd_out)); // R10
    AST_EMPTY_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_done && s_acc == '0) |-> (sd_out == OUT_W'(1 << FRAC))); // R8
    AST_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        div_go |-> !div_busy); // R7
    AST_BUSY_END_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (interval_end && state != ST_IDLE) |=> $stable(s_acc)); // R11
endmodule

bind slowdown_est sd_chk #(.CNT_W(CNT_W), .OUT_W(OUT_W), .FRAC(FRAC)) u_chk (
    .clk(clk), .rst_n(rst_n), .interval_end(interval_end),
    .sd_done(sd_done), .sd_out(sd_out), .state(state),
    .div_go(div_go), .div_busy(div_busy), .s_acc(s_acc)
);

// File: tb/sim_slowdown_est.sv
`timescale 1ns/1ps
module sim_slowdown_est;
    typedef struct packed {
        int len; int hp; int accp; int hpaccp; int lat; int cont; int ql;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{100, 50, 4, 2, 10, 0,  0},
        '{100, 40, 2, 2,  8, 2,  5},
        '{120, 60, 3, 1, 20, 1, 10},
        '{ 60, 20, 2, 2, 15, 5,  0},
        '{ 80, 30, 0, 0, 10, 0,  0},
        '{ 90, 45, 3, 2,  0, 3,  0},
        '{300, 20, 0, 1, 15, 5,  0}
    };

    logic clk = 0, rst_n = 0, interval_end = 0, acc_v = 0, hi_pri = 0;
    logic miss_iss_v = 0, miss_ret_v = 0;
    logic [1:0] miss_iss_tag = 0, miss_ret_tag = 0, last_sched_id = 0;
    logic [15:0] cont_miss_cnt = 0;
    logic [15:0] sd_out;
    logic sd_done;

    always #10 clk = ~clk;

    slowdown_est u0 (
        .clk(clk), .rst_n(rst_n), .interval_end(interval_end), .acc_v(acc_v),
        .hi_pri(hi_pri), .miss_iss_v(miss_iss_v), .miss_iss_tag(miss_iss_tag),
        .miss_ret_v(miss_ret_v), .miss_ret_tag(miss_ret_tag),
        .cont_miss_cnt(cont_miss_cnt), .last_sched_id(last_sched_id),
        .sd_out(sd_out), .sd_done(sd_done)
    );

    int tests = 0, fails = 0, done_cnt = 0;
    bit finished = 0, pend = 0;
    longint m_acc, m_cyc, m_acchp, m_cychp, m_q, m_lat, m_nd, t_now, iss_t;
    bit m_outst;
    longint exp_v, got;

    task automatic chk(input string tag, input longint act, input longint expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic longint model_exp(input longint cont);
        longint avg, den, e;
        avg = (m_nd != 0) ? m_lat / m_nd : 0;
        den = m_cychp - cont * avg - m_q;
        if (den < 1) den = 1;
        if (m_acc == 0) e = 256;
        else e = (m_acchp * m_cyc * 256) / (den * m_acc);
        if (e > 65535) e = 65535;
        return e;
    endfunction

    task automatic model_clear();
        m_acc = 0; m_cyc = 0; m_acchp = 0; m_cychp = 0; m_q = 0; m_lat = 0; m_nd = 0;
    endtask

    task automatic step(input bit a, input bit hp, input bit iss, input bit ret,
                        input logic [1:0] last, input bit iend, input int cont);
        @(negedge clk);
        if (sd_done) begin done_cnt++; got = sd_out; pend = 0; end
        acc_v = a; hi_pri = hp; miss_iss_v = iss; miss_ret_v = ret;
        miss_iss_tag = 0; miss_ret_tag = 0; last_sched_id = last;
        interval_end = iend; cont_miss_cnt = 16'(cont);
        m_cyc++; m_acc += a;
        if (hp) begin m_cychp++; m_acchp += a; end
        if (hp && m_outst && last != 0) m_q++;
        if (ret && hp) begin m_nd++; m_lat += t_now - iss_t; end
        if (ret) m_outst = 0;
        if (iss) begin m_outst = 1; iss_t = t_now; end
        t_now++;
        if (iend) begin
            if (!pend) begin exp_v = model_exp(cont); pend = 1; end
            model_clear();
        end
    endtask

    task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask

    task automatic wait_done(output bit ok);
        int start = done_cnt;
        ok = 0;
        for (int i = 0; i < 300; i++) begin
            idle();
            if (done_cnt != start) begin ok = 1; break; end
        end
    endtask

    task automatic run_vec(input vec_t v);
        for (int c = 0; c < v.len; c++) begin
            bit hp, a;
            hp = (c < v.hp);
            if (hp) a = (v.hpaccp != 0) && (c % v.hpaccp == 0);
            else    a = (v.accp != 0) && (c % v.accp == 0);
            step(a, hp, (c == 1) && (v.lat > 0), (v.lat > 0) && (c == 1 + v.lat),
                 (c >= 2 && c < 2 + v.ql) ? 2'd1 : 2'd0, c == v.len - 1, v.cont);
        end
    endtask

    function automatic string vtag(input int i);
        case (i)
            0: return "R2/R3/R7";
            1: return "R4/R6";
            2: return "R4/R5";
            3: return "R6 clamp";
            4: return "R8";
            5: return "R5 no-miss";
            default: return "R9";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit ok;
        int d0;
        longint held, first_exp;
        model_clear(); t_now = 0; iss_t = 0; m_outst = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 out in reset", sd_out, 0);
        chk("R1 done in reset", sd_done, 0);
        rst_n = 1;
        m_cyc = 1; m_outst = 0;
        @(negedge clk);
        chk("R1 out after reset", sd_out, 0);
        m_cyc++;
        t_now = 2;

        // table walk
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i]);
            wait_done(ok);
            chk({vtag(i), " done seen"}, ok, 1);
            chk(vtag(i), got, exp_v);
        end

        // R10: single pulse, output held
        held = sd_out;
        d0 = done_cnt;
        repeat (8) idle();
        chk("R10 extra pulses", done_cnt - d0, 0);
        chk("R10 output held", sd_out, held);

        // R11: interval end while computing
        run_vec(VECS[0]);
        first_exp = exp_v;
        d0 = done_cnt;
        repeat (3) idle();
        step(1, 1, 0, 0, 0, 1, 9);
        wait_done(ok);
        chk("R11 pending estimate", got, first_exp);
        repeat (200) idle();
        chk("R11 single estimate", done_cnt - d0, 1);
        run_vec(VECS[1]);
        wait_done(ok);
        chk("R11 counters restarted", got, exp_v);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule